// File: doc/BRIEF.md
# Buffered Burst Flash Programming Sequencer

This block drives a parallel asynchronous flash device through its high-throughput buffered programming mode. A host pulses `start` with a first word address and a word count. It then streams the data words over a valid/ready handshake. The sequencer enters the buffered mode with a two-command setup and checks whether the device accepted it. It then loops: it waits for the device to signal that it can take data, pushes one fixed-size burst of words, and waits for the device to finish programming that burst. When no data remains, it leaves the mode through an exit write to an address outside the target block. It waits for the device to confirm the exit, returns the device to array-read mode and pulses `done`.

Every bus access is a fixed-length strobe cycle set by a parameter. Each status poll that can repeat is limited by a software-supplied poll budget. Errors are reported on sticky flags that stay valid until the next `start`: misaligned start address, programming-voltage fault, locked block and poll timeout.

Top module: `burst_prog_seq`

## Requirements
- R1: A `start` whose address is not a multiple of BURST (32 words) is rejected: on the next cycle `done` pulses with `err_align` set, and no write or read strobe occurs.
- R2: An accepted request begins with two writes to the start address, data 0x0080 first and then 0x00D0.
- R3: After setup, one status read is made. If status bit 7 is 1, `err_vpp` takes status bit 3 and `err_lock` takes status bit 1. No data is written, no exit is issued, and the only further write is 0x00FF to the start address before `done`.
- R4: Before each burst, status is read repeatedly until bit 0 reads 0. No data word is written while the device reports bit 0 = 1.
- R5: Each burst is exactly 32 writes to the start address, carrying the stream words in arrival order.
- R6: After each burst, status is read until bit 0 reads 0. Only then is the next burst begun, or the exit issued when no words remain.
- R7: When the word count is not a multiple of 32, the last burst is completed with data 0xFFFF.
- R8: Exit writes 0xFFFF to the start address with address bit BLK_AW inverted (an address in another block). Status is then polled until bit 7 reads 1. A word count of 0 goes straight from setup to exit.
- R9: The last write of every accepted request is 0x00FF to the start address. `done` is high for exactly one cycle, and `busy` is low afterwards.
- R10: When a repeating poll reads not-ready `tmo_limit` times in a row, `err_tmo` is set. A burst-ready or program poll timeout still issues the exit sequence. A `tmo_limit` of 0 never times out.
- R11: `fwe_n` and `foe_n` are never low together. `fa` and `fdo` stay stable while `fwe_n` is held low. Both strobes stay high while idle.
- R12: `s_ready` is high only while a data slot is being filled and stream words remain, so exactly `word_count` stream words are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| start_addr | input | AW | First word address of the request |
| word_count | input | CW | Number of stream words to program |
| tmo_limit | input | TW | Not-ready reads allowed per poll; 0 disables |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DW | Stream word |
| s_ready | output | 1 | Stream word accepted this cycle when valid |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_align | output | 1 | Start address misaligned |
| err_vpp | output | 1 | Setup failed, programming voltage fault |
| err_lock | output | 1 | Setup failed, block locked |
| err_tmo | output | 1 | A status poll ran out of budget |
| fa | output | AW | Flash address |
| fdo | output | DW | Flash write data |
| fdi | input | DW | Flash read data (status in bits 7:0) |
| fwe_n | output | 1 | Flash write strobe, active low |
| foe_n | output | 1 | Flash read strobe, active low |

## Verification
The hardest case to reach from the ports is a program-completion poll that runs out of budget in the middle of a request. The sequencer must then still leave the buffered mode cleanly. The bench's behavioural flash model holds status bit 0 high for far more reads than a small `tmo_limit` allows after the first burst. It then checks the exact read count, the exit write to the neighbouring block and the closing 0x00FF. A second run uses a zero budget with a long busy period to show that the limit can be disabled. Bubbles in the stream and a short final burst check that padding never takes a host word.

// File: rtl/burst_prog_seq.sv
module burst_prog_seq #(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int TW     = 16,
  parameter int BURST  = 32,
  parameter int BLK_AW = 10,
  parameter int STROBE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_count,
  input  logic [TW-1:0] tmo_limit,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic          busy,
  output logic          done,
  output logic          err_align,
  output logic          err_vpp,
  output logic          err_lock,
  output logic          err_tmo,
  output logic [AW-1:0] fa,
  output logic [DW-1:0] fdo,
  input  logic [DW-1:0] fdi,
  output logic          fwe_n,
  output logic          foe_n
);
  localparam int BW      = $clog2(BURST);
  localparam int PH_LAST = STROBE + 1;
  localparam int PHW     = $clog2(PH_LAST + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD_SET, S_CMD_CONF, S_POLL_SET, S_POLL_RDY, S_FILL,
    S_POLL_PRG, S_EXIT_WR, S_POLL_EXIT, S_RDARR, S_DONE
  } st_t;

  st_t            st;
  logic [PHW-1:0] ph;
  logic [BW-1:0]  bcnt;
  logic [CW-1:0]  rem;
  logic [AW-1:0]  base;
  logic [DW-1:0]  wdat;
  logic [DW-1:0]  sr;
  logic [TW-1:0]  pcnt;

  logic wr_st, rd_st, strobe_on, op_end, hold, tmo_hit;
  logic unused_hi;

  assign wr_st = (st == S_CMD_SET) || (st == S_CMD_CONF) || (st == S_FILL) ||
                 (st == S_EXIT_WR) || (st == S_RDARR);
  assign rd_st = (st == S_POLL_SET) || (st == S_POLL_RDY) ||
                 (st == S_POLL_PRG) || (st == S_POLL_EXIT);
  assign strobe_on = (ph != '0) && (ph <= PHW'(STROBE));
  assign op_end    = (ph == PHW'(PH_LAST));
  assign s_ready   = (st == S_FILL) && (ph == '0) && (rem != '0);
  assign hold      = s_ready && !s_valid;
  assign tmo_hit   = (tmo_limit != '0) && ((pcnt + 1'b1) >= tmo_limit);
  assign unused_hi = ^sr[DW-1:8];

  assign fwe_n = !(wr_st && strobe_on);
  assign foe_n = !(rd_st && strobe_on);
  assign fa    = (st == S_EXIT_WR) ? (base ^ (AW'(1) << BLK_AW)) : base;
  assign fdo   = wdat;
  assign busy  = (st != S_IDLE);
  assign done  = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= '0;
      bcnt      <= '0;
      rem       <= '0;
      base      <= '0;
      wdat      <= '0;
      sr        <= '0;
      pcnt      <= '0;
      err_align <= 1'b0;
      err_vpp   <= 1'b0;
      err_lock  <= 1'b0;
      err_tmo   <= 1'b0;
    end else begin
      if ((wr_st || rd_st) && !hold)
        ph <= op_end ? '0 : ph + 1'b1;
      if (rd_st && ph == PHW'(STROBE))
        sr <= fdi;
      if (ph == '0) begin
        case (st)
          S_CMD_SET:  wdat <= DW'(16'h0080);
          S_CMD_CONF: wdat <= DW'(16'h00D0);
          S_EXIT_WR:  wdat <= {DW{1'b1}};
          S_RDARR:    wdat <= DW'(16'h00FF);
          S_FILL: begin
            if (rem == '0) wdat <= {DW{1'b1}};
            else if (s_valid) begin
              wdat <= s_data;
              rem  <= rem - 1'b1;
            end
          end
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (start) begin
          base      <= start_addr;
          rem       <= word_count;
          ph        <= '0;
          pcnt      <= '0;
          err_vpp   <= 1'b0;
          err_lock  <= 1'b0;
          err_tmo   <= 1'b0;
          err_align <= (start_addr[BW-1:0] != '0);
          st        <= (start_addr[BW-1:0] != '0) ? S_DONE : S_CMD_SET;
        end
        S_CMD_SET:  if (op_end) st <= S_CMD_CONF;
        S_CMD_CONF: if (op_end) st <= S_POLL_SET;
        S_POLL_SET: if (op_end) begin
          pcnt <= '0;
          if (!sr[7])
            st <= (rem == '0) ? S_EXIT_WR : S_POLL_RDY;
          else begin
            err_vpp  <= sr[3];
            err_lock <= sr[1];
            st       <= S_RDARR;
          end
        end
        S_POLL_RDY: if (op_end) begin
          if (!sr[0]) begin
            pcnt <= '0;
            bcnt <= '0;
            st   <= S_FILL;
          end else if (tmo_hit) begin
            err_tmo <= 1'b1;
            st      <= S_EXIT_WR;
          end else
            pcnt <= pcnt + 1'b1;
        end
        S_FILL: if (op_end) begin
          if (bcnt == BW'(BURST - 1)) begin
            bcnt <= '0;
            pcnt <= '0;
            st   <= S_POLL_PRG;
          end else
            bcnt <= bcnt + 1'b1;
        end
        S_POLL_PRG: if (op_end) begin
          if (!sr[0]) begin
            pcnt <= '0;
            st   <= (rem == '0) ? S_EXIT_WR : S_POLL_RDY;
          end else if (tmo_hit) begin
            err_tmo <= 1'b1;
            st      <= S_EXIT_WR;
          end else
            pcnt <= pcnt + 1'b1;
        end
        S_EXIT_WR: if (op_end) begin
          pcnt <= '0;
          st   <= S_POLL_EXIT;
        end
        S_POLL_EXIT: if (op_end) begin
          if (sr[7])
            st <= S_RDARR;
          else if (tmo_hit) begin
            err_tmo <= 1'b1;
            st      <= S_RDARR;
          end else
            pcnt <= pcnt + 1'b1;
        end
        S_RDARR: if (op_end) st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_prog_chk.sv
module burst_prog_chk #(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int BURST = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] start_addr,
  input logic          s_ready,
  input logic          busy,
  input logic          done,
  input logic          err_align,
  input logic [AW-1:0] fa,
  input logic [DW-1:0] fdo,
  input logic          fwe_n,
  input logic          foe_n
);
  localparam int BW = $clog2(BURST);

  assert_align_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (start_addr[BW-1:0] != '0)) |=> (done && err_align && fwe_n && foe_n));

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fwe_n && !foe_n));

  assert_wr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwe_n && $past(!fwe_n)) |-> ($stable(fa) && $stable(fdo)));

  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fwe_n && foe_n));

  assert_ready_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && fwe_n && foe_n));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

bind burst_prog_seq burst_prog_chk #(.AW(AW), .DW(DW), .BURST(BURST)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
  .s_ready(s_ready), .busy(busy), .done(done), .err_align(err_align),
  .fa(fa), .fdo(fdo), .fwe_n(fwe_n), .foe_n(foe_n)
);

// File: tb/burst_prog_seq_tb.sv
`timescale 1ns/1ps
module burst_prog_seq_tb;
  localparam int AW = 24, DW = 16, CW = 16, TW = 16, BLK = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic [TW-1:0] tmo_limit = '0;
  logic s_valid, s_ready, busy, done, err_align, err_vpp, err_lock, err_tmo;
  logic [DW-1:0] s_data, fdo, fdi;
  logic [AW-1:0] fa;
  logic fwe_n, foe_n;

  always #2.5 clk = ~clk;

  burst_prog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .tmo_limit(tmo_limit), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .busy(busy), .done(done),
    .err_align(err_align), .err_vpp(err_vpp), .err_lock(err_lock),
    .err_tmo(err_tmo), .fa(fa), .fdo(fdo), .fdi(fdi), .fwe_n(fwe_n), .foe_n(foe_n)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // stream source
  logic [DW-1:0] smem [0:127];
  int n_stream = 0, sidx = 0;
  logic gap_en = 1'b0, clr = 1'b0;
  logic [1:0] gcnt = '0;
  assign s_valid = (sidx < n_stream) && !(gap_en && gcnt == 2'd0);
  assign s_data  = smem[sidx[6:0]];
  always @(posedge clk) begin
    gcnt <= gcnt + 1'b1;
    if (clr) sidx <= 0;
    else if (s_valid && s_ready) sidx <= sidx + 1;
  end

  // flash model
  logic [7:0] cfg_fail = '0;
  int cfg_rdy = 0, cfg_prg = 0, cfg_ew = 0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW-1:0] wlog_a [0:511];
  logic [DW-1:0] wlog_d [0:511];
  logic [DW-1:0] prog [0:255];
  int nwr, nrd, nprog, viol, both_low, m_cnt, m_busy, m_ewait;
  logic m_befp, m_exit, m_pend, we_q, oe_q;
  logic [7:0] m_fail, m_sr;

  assign m_sr = {m_fail[7] | (m_exit && m_ewait == 0), 3'b000, m_fail[3], 1'b0,
                 m_fail[1], (m_busy != 0)};
  assign fdi = {8'h00, m_sr};

  always @(negedge clk) begin
    if (clr) begin
      nwr = 0; nrd = 0; nprog = 0; viol = 0; both_low = 0; m_cnt = 0; m_busy = 0;
      m_ewait = 0; m_befp = 0; m_exit = 0; m_pend = 0; m_fail = '0;
    end else if (rst_n) begin
      if (!fwe_n && !foe_n) both_low++;
      if (!we_q && fwe_n) begin
        if (nwr < 512) begin wlog_a[nwr] = fa; wlog_d[nwr] = fdo; end
        nwr++;
        if (!m_befp) begin
          if (fdo == 16'h0080) m_pend = 1;
          else if (m_pend && fdo == 16'h00D0) begin
            m_pend = 0;
            if (cfg_fail != 0) m_fail = cfg_fail;
            else begin m_befp = 1; m_busy = cfg_rdy; m_cnt = 0; end
          end else m_pend = 0;
        end else if (!m_exit) begin
          if (fa[AW-1:BLK] != cfg_base[AW-1:BLK] && fdo == 16'hFFFF) begin
            m_exit = 1; m_ewait = cfg_ew;
          end else begin
            if (m_busy != 0 || fa != cfg_base) viol++;
            if (nprog < 256) prog[nprog] = fdo;
            nprog++; m_cnt++;
            if (m_cnt == 32) begin m_cnt = 0; m_busy = cfg_prg; end
          end
        end else if (fdo == 16'h00FF) begin
          m_befp = 0; m_exit = 0;
        end
      end
      if (!oe_q && foe_n) begin
        nrd++;
        if (m_busy > 0) m_busy--;
        if (m_exit && m_ewait > 0) m_ewait--;
      end
    end
    we_q = fwe_n;
    oe_q = foe_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic prep(input int n, input logic [15:0] seed, input logic gap,
                      input logic [7:0] fail, input int rdy, input int prg, input int ew);
    for (int i = 0; i < 128; i++) smem[i] = seed + 16'(i * 7);
    n_stream = n; gap_en = gap;
    cfg_fail = fail; cfg_rdy = rdy; cfg_prg = prg; cfg_ew = ew;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic run(input logic [AW-1:0] a, input int n, input logic [TW-1:0] tl,
                     output bit got);
    int k;
    cfg_base = a; start_addr = a; word_count = CW'(n); tmo_limit = tl;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    got = 0;
    k = 0;
    while (!got && k < 20000) begin
      if (done) got = 1;
      else begin @(negedge clk); k++; end
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R11 reset strobes", {fwe_n, foe_n}, 2'b11);
    chk("R12 reset s_ready", s_ready, 0);
  endtask

  task automatic t_misaligned;
    bit got;
    prep(32, 16'h1000, 0, 8'h00, 0, 0, 0);
    run(24'h000405, 32, 0, got);
    chk("R1 done", got, 1);
    chk("R1 err_align", err_align, 1);
    chk("R1 no bus", nwr + nrd, 0);
    chk("R1 busy low", busy, 0);
  endtask

  task automatic t_normal;
    bit got;
    logic [AW-1:0] a = 24'h012C00;
    prep(64, 16'hA000, 0, 8'h00, 3, 5, 2);
    run(a, 64, 100, got);
    chk("R9 done", got, 1);
    chk("R2 first cmd", {wlog_a[0], wlog_d[0]}, {a, 16'h0080});
    chk("R2 confirm", {wlog_a[1], wlog_d[1]}, {a, 16'h00D0});
    chk("R5 data count", nprog, 64);
    for (int i = 0; i < 64; i++)
      if (prog[i] !== smem[i]) chk("R5 data word", prog[i], smem[i]);
    chk("R5 data at base, R4 no early write", viol, 0);
    chk("R8 exit write", {wlog_a[66], wlog_d[66]}, {a ^ 24'h000400, 16'hFFFF});
    chk("R9 read array", {wlog_a[67], wlog_d[67]}, {a, 16'h00FF});
    chk("R9 write total", nwr, 68);
    chk("R4 R6 R8 read total", nrd, 20);
    chk("R9 errors clear", {err_align, err_vpp, err_lock, err_tmo}, 4'b0000);
    chk("R11 strobe overlap", both_low, 0);
    chk("R9 busy after done", busy, 0);
  endtask

  task automatic t_partial;
    bit got;
    logic [AW-1:0] a = 24'h003060;
    prep(40, 16'h5000, 1, 8'h00, 0, 2, 0);
    run(a, 40, 50, got);
    chk("R7 done", got, 1);
    chk("R7 data count", nprog, 64);
    for (int i = 0; i < 40; i++)
      if (prog[i] !== smem[i]) chk("R5 data word gapped", prog[i], smem[i]);
    for (int i = 40; i < 64; i++)
      if (prog[i] !== 16'hFFFF) chk("R7 pad word", prog[i], 16'hFFFF);
    chk("R12 consumed", sidx, 40);
    chk("R7 no violation", viol, 0);
  endtask

  task automatic t_fail(input logic [7:0] f, input logic ev, input logic el);
    bit got;
    logic [AW-1:0] a = 24'h000800;
    prep(32, 16'h2000, 0, f, 0, 0, 0);
    run(a, 32, 10, got);
    chk("R3 done", got, 1);
    chk("R3 err_vpp", err_vpp, ev);
    chk("R3 err_lock", err_lock, el);
    chk("R3 no data", nprog, 0);
    chk("R3 writes", nwr, 3);
    chk("R3 last write", {wlog_a[2], wlog_d[2]}, {a, 16'h00FF});
    chk("R3 one poll", nrd, 1);
    chk("R12 none consumed", sidx, 0);
  endtask

  task automatic t_timeout;
    bit got;
    logic [AW-1:0] a = 24'h040000;
    prep(32, 16'h7700, 0, 8'h00, 0, 1000, 0);
    run(a, 32, 4, got);
    chk("R10 done", got, 1);
    chk("R10 err_tmo", err_tmo, 1);
    chk("R10 reads", nrd, 7);
    chk("R10 exit still issued", {wlog_a[34], wlog_d[34]}, {a ^ 24'h000400, 16'hFFFF});
    chk("R10 read array", {wlog_a[35], wlog_d[35]}, {a, 16'h00FF});
  endtask

  task automatic t_no_limit;
    bit got;
    prep(32, 16'h3300, 0, 8'h00, 0, 20, 0);
    run(24'h001000, 32, 0, got);
    chk("R10 done no limit", got, 1);
    chk("R10 no timeout when 0", err_tmo, 0);
    chk("R10 reads no limit", nrd, 1 + 1 + 21 + 1);
  endtask

  task automatic t_zero;
    bit got;
    logic [AW-1:0] a = 24'h000C00;
    prep(0, 16'h0, 0, 8'h00, 0, 0, 1);
    run(a, 0, 10, got);
    chk("R8 done zero", got, 1);
    chk("R8 writes zero", nwr, 4);
    chk("R8 exit zero", {wlog_a[2], wlog_d[2]}, {a ^ 24'h000400, 16'hFFFF});
    chk("R8 exit poll", nrd, 1 + 2);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_misaligned;
    t_normal;
    t_partial;
    t_fail(8'h88, 1, 0);
    t_fail(8'h82, 0, 1);
    t_timeout;
    t_no_limit;
    t_zero;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule